// File: doc/BRIEF.md
# Multi-Mode Up/Down Counter with Index Actions

This block is a binary up/down counter advanced by single-cycle count strobes, with the direction given by a separate bit. It holds a preset value and an output latch next to the count. A two-bit mode field sets what happens at the ends of the count range. The counter can wrap freely, stop after its first overflow or underflow, stop at zero and at the preset value, or wrap between zero and the preset value so that the count rate is divided by preset+1.

A separate index input, with programmable active level, can trigger one of four actions on its inactive-to-active edge: no action, copy the preset into the counter, clear the counter, or copy the counter into the output latch. A global disable bit blocks all counting. The host writes the preset and issues clear and load commands as one-cycle strobes. The block reports carry, borrow, compare and rollover as one-cycle event pulses for a later flag stage to format.

Top module: `modal_updown_counter`

## Requirements
- R1: After reset the count, preset, output latch, halted status and all event outputs are zero.
- R2: In mode 2'b00 (free) an up step adds one and a down step subtracts one, modulo 2^W. An up step from all-ones gives zero and pulses ev_carry. A down step from zero gives all-ones and pulses ev_borrow.
- R3: Mode 2'b01 (single) steps like mode 00. A step that produces a carry or a borrow sets halted. While halted, strobes leave the count unchanged. A host clear, host load, index load or index clear releases halted.
- R4: In mode 2'b10 (range) an up step holds the count when it is at or above the preset. A down step holds the count at zero. Otherwise the count steps by one, so reversing the direction resumes counting at once.
- R5: In mode 2'b11 (modulo) an up step from a count equal to the preset gives zero. A down step from zero gives the preset. Both pulse ev_roll. All other steps move by one, with a carry at all-ones as in R2.
- R6: ev_compare pulses in the cycle after a step that was not held and that leaves the count equal to the preset.
- R7: idx_func selects the action on an index edge: 2'b00 none, 2'b01 count takes the preset, 2'b10 count is cleared, 2'b11 latch_q takes the count. The action fires only on the inactive-to-active transition, never on a held active level. When the action is not 2'b00, a count strobe in the same cycle is ignored.
- R8: The index is active when idx_in equals idx_pol, so idx_pol=0 selects an active-low index and idx_pol=1 an active-high index.
- R9: While cnt_dis is 1, count strobes have no effect on the count.
- R10: Priority is host_clr, then host_load, then the index action, then the count strobe. A preset written in the same cycle as a load takes effect from the next cycle, so the load uses the old preset.
- R11: Each event output is a one-cycle pulse, valid together with the updated count, and carry and borrow never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_mode | input | 2 | Range behaviour: 00 free, 01 single, 10 range, 11 modulo |
| idx_func | input | 2 | Index action: 00 none, 01 load, 10 clear, 11 latch |
| idx_pol | input | 1 | Index active level |
| cnt_dis | input | 1 | 1 blocks counting |
| cnt_stb | input | 1 | Count strobe, one step per cycle |
| cnt_up | input | 1 | Direction, 1 = up |
| idx_in | input | 1 | Filtered index input |
| pr_wr | input | 1 | Preset write strobe |
| pr_wdata | input | W | Preset write data |
| host_clr | input | 1 | Clear counter strobe |
| host_load | input | 1 | Load preset into counter strobe |
| count | output | W | Counter value |
| preset_q | output | W | Preset value |
| latch_q | output | W | Output latch value |
| halted | output | 1 | Single mode stopped after carry or borrow |
| ev_carry | output | 1 | Carry pulse |
| ev_borrow | output | 1 | Borrow pulse |
| ev_compare | output | 1 | Step landed on preset pulse |
| ev_roll | output | 1 | Modulo wrap pulse |

## Verification
The bench sweeps every mode, every preset and every start value of a 4-bit counter in both directions, taking two steps each time. This reaches the boundaries at zero, at the preset and at all-ones. A design that held at the preset one step late, wrapped the modulo counter at all-ones instead of the preset, or flagged compare on a held step would show a wrong count or a wrong pulse there. Directed cases target index edges against held levels and the index polarity. They also cover strobes that coincide with an index action, the release of the single-mode halt, and the host clear, host load and index priority. A design that acted on the level, ignored the polarity or let a strobe slip past an index action would show a wrong count or latch value.

// File: rtl/mcnt_pkg.sv
package mcnt_pkg;
  typedef enum logic [1:0] {
    MODE_FREE   = 2'b00,
    MODE_SINGLE = 2'b01,
    MODE_RANGE  = 2'b10,
    MODE_MODN   = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    IDX_NONE  = 2'b00,
    IDX_LOAD  = 2'b01,
    IDX_CLEAR = 2'b10,
    IDX_LATCH = 2'b11
  } idx_func_e;
endpackage

// File: rtl/mcnt_index_gate.sv
module mcnt_index_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic idx_in,
  input  logic idx_pol,
  output logic idx_edge
);
  logic act;
  logic act_d;

  assign act = (idx_in == idx_pol);

  // Treat the index as already active out of reset so no spurious edge fires.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_d <= 1'b1;
    else        act_d <= act;
  end

  assign idx_edge = act & ~act_d;

  // R7: an edge can never repeat on the following cycle
  a_r7_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    idx_edge |=> !idx_edge);
  // R8: an edge only occurs while the index sits at its active level
  a_r8_edge_level: assert property (@(posedge clk) disable iff (!rst_n)
    idx_edge |-> (idx_in == idx_pol));
endmodule

// File: rtl/mcnt_step_unit.sv
module mcnt_step_unit #(
  parameter int W = 32
) (
  input  logic [1:0]   mode,
  input  logic         up,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] pr,
  output logic [W-1:0] nxt,
  output logic         carry,
  output logic         borrow,
  output logic         roll,
  output logic         held,
  output logic         cmp_hit
);
  import mcnt_pkg::*;

  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] ZERO     = '0;
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  typedef struct packed {
    logic [W-1:0] v;
    logic         c;
    logic         b;
    logic         r;
    logic         h;
  } res_t;

  function automatic res_t calc_step(input cnt_mode_e m, input logic dir_up,
                                     input logic [W-1:0] c, input logic [W-1:0] p);
    res_t o;
    o = '{v: c, c: 1'b0, b: 1'b0, r: 1'b0, h: 1'b0};
    unique case (m)
      MODE_FREE, MODE_SINGLE: begin
        if (dir_up) begin
          o.v = c + ONE;
          o.c = (c == ALL_ONES);
        end else begin
          o.v = c - ONE;
          o.b = (c == ZERO);
        end
      end
      MODE_RANGE: begin
        if (dir_up) begin
          if (c >= p) o.h = 1'b1;
          else        o.v = c + ONE;
        end else begin
          if (c == ZERO) o.h = 1'b1;
          else           o.v = c - ONE;
        end
      end
      MODE_MODN: begin
        if (dir_up) begin
          if (c == p) begin
            o.v = ZERO;
            o.r = 1'b1;
          end else begin
            o.v = c + ONE;
            o.c = (c == ALL_ONES);
          end
        end else begin
          if (c == ZERO) begin
            o.v = p;
            o.r = 1'b1;
          end else begin
            o.v = c - ONE;
          end
        end
      end
      default: o.h = 1'b1;
    endcase
    return o;
  endfunction

  res_t res;
  assign res     = calc_step(cnt_mode_e'(mode), up, cur, pr);
  assign nxt     = res.v;
  assign carry   = res.c;
  assign borrow  = res.b;
  assign roll    = res.r;
  assign held    = res.h;
  assign cmp_hit = ~res.h & (res.v == pr);
endmodule

// File: rtl/mcnt_event_reg.sv
module mcnt_event_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic carry,
  input  logic borrow,
  input  logic roll,
  input  logic cmp_hit,
  output logic ev_carry,
  output logic ev_borrow,
  output logic ev_roll,
  output logic ev_compare
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_carry   <= 1'b0;
      ev_borrow  <= 1'b0;
      ev_roll    <= 1'b0;
      ev_compare <= 1'b0;
    end else begin
      ev_carry   <= step_en & carry;
      ev_borrow  <= step_en & borrow;
      ev_roll    <= step_en & roll;
      ev_compare <= step_en & cmp_hit;
    end
  end

  // R11: events appear only after an accepted step
  a_r11_roll_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_roll |-> $past(step_en));
endmodule

// File: rtl/modal_updown_counter.sv
module modal_updown_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   cnt_mode,
  input  logic [1:0]   idx_func,
  input  logic         idx_pol,
  input  logic         cnt_dis,
  input  logic         cnt_stb,
  input  logic         cnt_up,
  input  logic         idx_in,
  input  logic         pr_wr,
  input  logic [W-1:0] pr_wdata,
  input  logic         host_clr,
  input  logic         host_load,
  output logic [W-1:0] count,
  output logic [W-1:0] preset_q,
  output logic [W-1:0] latch_q,
  output logic         halted,
  output logic         ev_carry,
  output logic         ev_borrow,
  output logic         ev_compare,
  output logic         ev_roll
);
  import mcnt_pkg::*;

  localparam logic [W-1:0] ZERO = '0;

  // Named internal events
  logic         idx_edge;
  logic         idx_go;
  logic         idx_ld;
  logic         idx_cl;
  logic         idx_ol;
  logic         host_any;
  logic         step_en;
  logic [W-1:0] step_nxt;
  logic         step_carry;
  logic         step_borrow;
  logic         step_roll;
  logic         step_held;
  logic         step_cmp;
  logic         halt_set;
  logic         halt_clr;
  idx_func_e    func;

  assign func = idx_func_e'(idx_func);

  mcnt_index_gate u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_in   (idx_in),
    .idx_pol  (idx_pol),
    .idx_edge (idx_edge)
  );

  mcnt_step_unit #(.W(W)) u_step (
    .mode    (cnt_mode),
    .up      (cnt_up),
    .cur     (count),
    .pr      (preset_q),
    .nxt     (step_nxt),
    .carry   (step_carry),
    .borrow  (step_borrow),
    .roll    (step_roll),
    .held    (step_held),
    .cmp_hit (step_cmp)
  );

  // Priority: host clear > host load > index action > count strobe
  assign host_any = host_clr | host_load;
  assign idx_go   = idx_edge & (func != IDX_NONE) & ~host_any;
  assign idx_ld   = idx_go & (func == IDX_LOAD);
  assign idx_cl   = idx_go & (func == IDX_CLEAR);
  assign idx_ol   = idx_go & (func == IDX_LATCH);
  assign step_en  = cnt_stb & ~cnt_dis & ~halted & ~host_any & ~idx_go;

  assign halt_clr = host_any | idx_ld | idx_cl;
  assign halt_set = step_en & (cnt_mode_e'(cnt_mode) == MODE_SINGLE)
                  & (step_carry | step_borrow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= ZERO;
    else if (host_clr)         count <= ZERO;
    else if (host_load)        count <= preset_q;
    else if (idx_cl)           count <= ZERO;
    else if (idx_ld)           count <= preset_q;
    else if (step_en)          count <= step_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      preset_q <= ZERO;
    else if (pr_wr)  preset_q <= pr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      latch_q <= ZERO;
    else if (idx_ol) latch_q <= count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        halted <= 1'b0;
    else if (halt_clr) halted <= 1'b0;
    else if (halt_set) halted <= 1'b1;
  end

  mcnt_event_reg u_ev (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .carry      (step_carry),
    .borrow     (step_borrow),
    .roll       (step_roll),
    .cmp_hit    (step_cmp),
    .ev_carry   (ev_carry),
    .ev_borrow  (ev_borrow),
    .ev_roll    (ev_roll),
    .ev_compare (ev_compare)
  );

  // R2: a carry leaves the counter at zero, a borrow at all-ones
  a_r2_carry_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ev_carry |-> (count == ZERO));
  a_r2_borrow_ones: assert property (@(posedge clk) disable iff (!rst_n)
    ev_borrow |-> (&count));
  // R3: while halted, only clear/load actions may move the count
  a_r3_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !host_any && !idx_ld && !idx_cl) |=> $stable(count));
  // R4: range mode holds at or above the preset when counting up
  a_r4_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cnt_mode == 2'b10 && cnt_up && count >= preset_q) |=> $stable(count));
  // R5: an up-direction modulo wrap lands on zero
  a_r5_roll_up_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_roll && $past(cnt_up)) |-> (count == ZERO));
  // R7: a latch action captures the count of the edge cycle
  a_r7_latch_copy: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ol |=> (latch_q == $past(count)));
  // R9: disabled counting leaves the count alone
  a_r9_dis_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_dis && !host_any && !idx_ld && !idx_cl) |=> $stable(count));
  // R10: host clear wins over everything
  a_r10_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    host_clr |=> (count == ZERO));
  // R11: carry and borrow are exclusive
  a_r11_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_carry && ev_borrow));
endmodule

// File: tb/tb_modal_updown_counter.sv
module tb_modal_updown_counter;
  localparam int W = 4;
  localparam int M = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] cnt_mode, idx_func;
  logic idx_pol, cnt_dis, cnt_stb, cnt_up, idx_in, pr_wr, host_clr, host_load;
  logic [W-1:0] pr_wdata;
  logic [W-1:0] count, preset_q, latch_q;
  logic halted, ev_carry, ev_borrow, ev_compare, ev_roll;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  modal_updown_counter #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_mode(cnt_mode), .idx_func(idx_func),
    .idx_pol(idx_pol), .cnt_dis(cnt_dis), .cnt_stb(cnt_stb), .cnt_up(cnt_up),
    .idx_in(idx_in), .pr_wr(pr_wr), .pr_wdata(pr_wdata), .host_clr(host_clr),
    .host_load(host_load), .count(count), .preset_q(preset_q), .latch_q(latch_q),
    .halted(halted), .ev_carry(ev_carry), .ev_borrow(ev_borrow),
    .ev_compare(ev_compare), .ev_roll(ev_roll)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_pr(input int v);
    pr_wr = 1'b1; pr_wdata = v[W-1:0];
    tick();
    pr_wr = 1'b0;
  endtask

  task automatic load_val(input int v);
    set_pr(v);
    host_load = 1'b1;
    tick();
    host_load = 1'b0;
  endtask

  task automatic strobe(input logic dir);
    cnt_stb = 1'b1; cnt_up = dir;
    tick();
    cnt_stb = 1'b0;
  endtask

  initial begin
    int c, h, ec, eb, er, ecmp, nc, hl;
    string tag;
    rst_n = 1'b0; cnt_mode = 2'b00; idx_func = 2'b00; idx_pol = 1'b0;
    cnt_dis = 1'b0; cnt_stb = 1'b0; cnt_up = 1'b1; idx_in = 1'b1;
    pr_wr = 1'b0; pr_wdata = '0; host_clr = 1'b0; host_load = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 preset", preset_q, 0);
    chk("R1 latch", latch_q, 0);
    chk("R1 halted", halted, 0);
    chk("R1 events", {ev_carry, ev_borrow, ev_compare, ev_roll}, 0);

    // Sweep: every mode, preset, start value and direction, two steps each
    for (int m = 0; m < 4; m++) begin
      cnt_mode = m[1:0];
      case (m)
        0: tag = "R2";
        1: tag = "R3";
        2: tag = "R4";
        default: tag = "R5";
      endcase
      for (int p = 0; p < M; p++) begin
        for (int s = 0; s < M; s++) begin
          for (int d = 0; d < 2; d++) begin
            load_val(s);
            set_pr(p);
            c = s; h = 0;
            for (int k = 0; k < 2; k++) begin
              ec = 0; eb = 0; er = 0; ecmp = 0; nc = c; hl = 0;
              if (h == 0) begin
                if (m < 2) begin
                  if (d == 1) begin nc = (c + 1) % M; ec = (c == M - 1); end
                  else        begin nc = (c + M - 1) % M; eb = (c == 0); end
                end else if (m == 2) begin
                  if (d == 1) begin if (c < p) nc = c + 1; else hl = 1; end
                  else        begin if (c > 0) nc = c - 1; else hl = 1; end
                end else begin
                  if (d == 1) begin
                    if (c == p) begin nc = 0; er = 1; end
                    else begin nc = (c + 1) % M; ec = (c == M - 1); end
                  end else begin
                    if (c == 0) begin nc = p; er = 1; end
                    else nc = c - 1;
                  end
                end
                ecmp = (hl == 0) && (nc == p);
                if (m == 1 && (ec || eb)) h = 1;
              end else begin
                hl = 1;
              end
              strobe(d[0]);
              chk(tag, count, nc);
              chk("R6 compare", ev_compare, ecmp);
              chk("R11 carry/borrow/roll", {ev_carry, ev_borrow, ev_roll}, {ec[0], eb[0], er[0]});
              chk("R3 halted", halted, h);
              c = nc;
            end
            tick();
            chk("R11 pulse ends", {ev_carry, ev_borrow, ev_compare, ev_roll}, 0);
          end
        end
      end
    end

    // R3 release by host clear
    cnt_mode = 2'b01;
    load_val(15);
    strobe(1'b1);
    chk("R3 halt set", halted, 1);
    strobe(1'b1);
    chk("R3 held", count, 0);
    host_clr = 1'b1; tick(); host_clr = 1'b0;
    chk("R3 released", halted, 0);
    strobe(1'b1);
    chk("R3 resumes", count, 1);

    // R7 index actions, active-low polarity
    cnt_mode = 2'b00;
    idx_func = 2'b01;
    load_val(3);
    set_pr(9);
    idx_in = 1'b0; cnt_stb = 1'b1; cnt_up = 1'b1;
    tick();
    chk("R7 load and strobe ignored", count, 9);
    tick();
    cnt_stb = 1'b0;
    chk("R7 level does not retrigger", count, 10);
    idx_in = 1'b1; tick();
    idx_func = 2'b10;
    idx_in = 1'b0; tick(); idx_in = 1'b1; tick();
    chk("R7 clear", count, 0);
    idx_func = 2'b11;
    load_val(5);
    idx_in = 1'b0; cnt_stb = 1'b1; tick(); cnt_stb = 1'b0; idx_in = 1'b1; tick();
    chk("R7 latch", latch_q, 5);
    chk("R7 latch count kept", count, 5);
    idx_func = 2'b00;
    idx_in = 1'b0; cnt_stb = 1'b1; tick(); cnt_stb = 1'b0;
    chk("R7 none lets strobe through", count, 6);

    // R8 active-high polarity (idx_in is 0 and func none here)
    idx_pol = 1'b1; tick();
    idx_func = 2'b10;
    load_val(7);
    idx_in = 1'b1; tick();
    chk("R8 rising edge acts", count, 0);
    load_val(7);
    idx_in = 1'b0; tick();
    chk("R8 falling edge ignored", count, 7);
    idx_func = 2'b00; idx_pol = 1'b0; tick();
    idx_in = 1'b1; tick();

    // R9 disable
    load_val(4);
    cnt_dis = 1'b1;
    strobe(1'b1); strobe(1'b1); strobe(1'b0);
    chk("R9 disabled", count, 4);
    cnt_dis = 1'b0;
    strobe(1'b1);
    chk("R9 enabled again", count, 5);

    // R10 priority
    set_pr(11);
    host_clr = 1'b1; host_load = 1'b1; cnt_stb = 1'b1;
    tick();
    host_clr = 1'b0; host_load = 1'b0; cnt_stb = 1'b0;
    chk("R10 clear over load", count, 0);
    idx_func = 2'b10;
    host_load = 1'b1; idx_in = 1'b0; cnt_stb = 1'b1;
    tick();
    host_load = 1'b0; cnt_stb = 1'b0; idx_in = 1'b1;
    chk("R10 load over index", count, 11);
    tick();
    idx_func = 2'b01;
    load_val(2);
    set_pr(13);
    pr_wr = 1'b1; pr_wdata = 4'd6; host_load = 1'b1;
    tick();
    pr_wr = 1'b0; host_load = 1'b0;
    chk("R10 load uses old preset", count, 13);
    chk("R10 preset updated", preset_q, 6);
    host_clr = 1'b1; idx_in = 1'b0;
    tick();
    host_clr = 1'b0; idx_in = 1'b1;
    chk("R10 clear over index load", count, 0);
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule